// File: doc/BRIEF.md
# Single DMA Channel Transfer Engine

This block moves data for one DMA channel. Software programs a working source address, destination address and element count through a small register write port, then writes a control word. The control word picks the element size, how each address moves, the data flow, the transfer mode, which values are restored from their saved copies, and whether a bus read error stops the channel. A transfer starts on a software request bit in the control word or on a pulse of the hardware request input. Each element is moved over a single-beat bus master port, and the element count goes down by one per element.

The bus port is valid/ready. `bus_req` is the valid signal, and it stays high with address, direction, size and write data unchanged until the cycle in which `bus_ready` is sampled high. That cycle completes the beat. The slave may hold `bus_ready` low for any number of cycles as back-pressure. `bus_rdata` and `bus_err` are looked at only in a completing read beat. Only one beat is ever outstanding. The request, interrupt, trap and status pins are plain level or pulse signals.

Register select codes on `cfg_sel`: 0 is control, 1 is source address, 2 is destination address, 3 is element count.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every output is low: `bus_req`, `bus_we`, `irq_done`, `irq_half`, `trap`, `chan_active` and `soft_req_pending`.
- R2: After each element the source address moves by the mode in control bits [13:12] and the destination address by the mode in control bits [11:10]. Mode 00 holds the address, 01 adds the step and 10 subtracts it. The step comes from the size field in control bits [5:4]: 00 is 1 byte, 01 is 2 bytes and 10 is 4 bytes. `bus_size` carries the size field.
- R3: With flow code 00 in control bits [7:6], an element is a read at the source address followed by a write, at the destination address, of the data just read.
- R4: With flow code 01, the destination write is followed by a third beat that writes the same data back to the source address.
- R5: With flow code 10, an element is only a read at the source address. No write beat is issued.
- R6: Transfer mode is in control bits [9:8]. Bit 9 set (continuous) means one request runs elements until the count reaches zero. Bit 9 clear (one-shot) means each request moves exactly one element.
- R7: When the count reaches zero, `irq_done` pulses for one cycle after the final beat, provided done-enable (control bit 2) is set. The software request bit (control bit 3, seen on `soft_req_pending`) clears whenever a request has been served. In non-repeated modes (bit 8 clear) `chan_active` drops.
- R8: In repeated modes (bit 8 set), reaching zero restores the count from its saved copy whatever control bit 17 says. It also restores the source address if control bit 15 is set and the destination address if control bit 16 is set. The channel stays active and waits for the next request.
- R9: A request taken from the inactive state first restores the source address (bit 15), the destination address (bit 16) and the count (bit 17, or any repeated mode). A request whose resulting count is zero is dropped with no bus beat, and its software request bit clears.
- R10: Writing an address or count register loads both its working and its saved copy. Only the working copy moves as elements complete.
- R11: With trap-enable (control bit 14) set, a read beat completing with `bus_err` high sets `trap`, stops the channel, and makes it ignore requests until the next control write. With trap-enable clear, the read data is used as usual and the run continues.
- R12: With half-enable (control bit 1) set, `irq_half` pulses one cycle after the element that leaves the working count equal to half the saved count (rounded down), when that half is nonzero.
- R13: With channel enable (control bit 0) clear, `bus_req` is low from the next cycle on, the channel becomes inactive, and neither request source starts a transfer.
- R14: While `bus_req` is high and `bus_ready` is low, the next cycle keeps `bus_req` high with `bus_addr`, `bus_we` and `bus_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | 32 | Register write data |
| hw_req | input | 1 | Hardware transfer request |
| bus_req | output | 1 | Bus beat valid |
| bus_ready | input | 1 | Bus beat accepted / completed |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 24 | Beat byte address |
| bus_size | output | 2 | Element size code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready on a read |
| bus_err | input | 1 | Read error, valid with bus_ready on a read |
| irq_done | output | 1 | Count-reached-zero interrupt pulse |
| irq_half | output | 1 | Halfway interrupt pulse |
| trap | output | 1 | Channel stopped on a read error |
| chan_active | output | 1 | Channel is running or waiting in a started operation |
| soft_req_pending | output | 1 | Software request bit still set |

## Verification
The bench builds the block with its default widths: 24-bit addresses, a 32-bit count and 32-bit data. Element counts are kept between one and twenty, so every mode runs to its zero count, and reloads and the halfway mark are reached within a few hundred cycles. Full-width addresses let randomly placed buffers step up and down with every size. A bus slave with random back-pressure and a one-shot error injector checks each beat against a reference model of the address and flow rules.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CB_EN   = 0;
  localparam int CB_HALF = 1;
  localparam int CB_DONE = 2;
  localparam int CB_SW   = 3;
  localparam int CB_SIZE = 4;
  localparam int CB_FLOW = 6;
  localparam int CB_XM   = 8;
  localparam int CB_DM   = 10;
  localparam int CB_SM   = 12;
  localparam int CB_TRAP = 14;
  localparam int CB_RLS  = 15;
  localparam int CB_RLD  = 16;
  localparam int CB_RLC  = 17;
  localparam int CTL_W   = 18;

  localparam logic [1:0] FLOW_COPY = 2'b00;
  localparam logic [1:0] FLOW_NULW = 2'b01;

  localparam logic [1:0] AM_INC = 2'b01;
  localparam logic [1:0] AM_DEC = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RD,
    ST_WR,
    ST_WB
  } seq_state_e;

  function automatic logic [2:0] step_bytes(input logic [1:0] size);
    case (size)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_val,
  input  logic          reload,
  input  logic          step,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] saved_q;
  logic [AW-1:0] delta;

  assign delta = AW'(step_bytes(size));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      saved_q <= '0;
    end else if (wr_en) begin
      addr    <= wr_val;
      saved_q <= wr_val;
    end else if (reload) begin
      addr <= saved_q;
    end else if (step) begin
      if (mode == AM_INC)      addr <= addr + delta;
      else if (mode == AM_DEC) addr <= addr - delta;
    end
  end
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          reload,
  input  logic          dec,
  output logic          cnt_nz,
  output logic          saved_nz,
  output logic          cnt_is_one,
  output logic          half_hit
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] saved_q;
  logic [CW-1:0] half_mark;

  assign half_mark  = saved_q >> 1;
  assign cnt_nz     = (cnt_q != '0);
  assign saved_nz   = (saved_q != '0);
  assign cnt_is_one = (cnt_q == ONE);
  assign half_hit   = dec && (half_mark != '0) && ((cnt_q - ONE) == half_mark);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      saved_q <= '0;
    end else if (wr_en) begin
      cnt_q   <= wr_val;
      saved_q <= wr_val;
    end else if (reload) begin
      cnt_q <= saved_q;
    end else if (dec) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       trap_en,
  input  logic       trap_q,
  input  logic [1:0] xmode,
  input  logic [1:0] flow,
  input  logic       rl_cnt,
  input  logic       req,
  input  logic       cnt_nz,
  input  logic       saved_nz,
  input  logic       cnt_is_one,
  input  logic       bus_ready,
  input  logic       bus_err,
  output seq_state_e state,
  output logic       start_ld,
  output logic       elem_done,
  output logic       last_done,
  output logic       rep_reload,
  output logic       trap_set,
  output logic       swreq_clr
);
  seq_state_e nxt;
  logic repeated, cont, eff_nz, rd_only;

  assign repeated = xmode[0];
  assign cont     = xmode[1];
  assign eff_nz   = (rl_cnt || repeated) ? saved_nz : cnt_nz;
  assign rd_only  = (flow != FLOW_COPY) && (flow != FLOW_NULW);

  always_comb begin
    nxt        = state;
    start_ld   = 1'b0;
    elem_done  = 1'b0;
    last_done  = 1'b0;
    rep_reload = 1'b0;
    trap_set   = 1'b0;
    swreq_clr  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (en && req && !trap_q) begin
          if (eff_nz) begin
            start_ld = 1'b1;
            nxt      = ST_RD;
          end else begin
            swreq_clr = 1'b1;
          end
        end
      end
      ST_ARMED: if (req) nxt = ST_RD;
      ST_RD: begin
        if (bus_ready) begin
          if (bus_err && trap_en) begin
            trap_set  = 1'b1;
            swreq_clr = 1'b1;
            nxt       = ST_IDLE;
          end else if (rd_only) begin
            elem_done = 1'b1;
          end else begin
            nxt = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (bus_ready) begin
          if (flow == FLOW_NULW) nxt = ST_WB;
          else                   elem_done = 1'b1;
        end
      end
      ST_WB: if (bus_ready) elem_done = 1'b1;
      default: nxt = ST_IDLE;
    endcase

    if (elem_done) begin
      if (cnt_is_one) begin
        last_done = 1'b1;
        swreq_clr = 1'b1;
        if (repeated) begin
          rep_reload = 1'b1;
          nxt        = saved_nz ? ST_ARMED : ST_IDLE;
        end else begin
          nxt = ST_IDLE;
        end
      end else if (cont) begin
        nxt = ST_RD;
      end else begin
        swreq_clr = 1'b1;
        nxt       = ST_ARMED;
      end
    end

    if (!en) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 32,
  parameter int DW = 32,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  input  logic          hw_req,
  output logic          bus_req,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err,
  output logic          irq_done,
  output logic          irq_half,
  output logic          trap,
  output logic          chan_active,
  output logic          soft_req_pending
);
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_SRC = 2'd1;
  localparam logic [1:0] SEL_DST = 2'd2;
  localparam logic [1:0] SEL_CNT = 2'd3;

  logic [CTL_W-1:0] ctl_q;
  logic [DW-1:0]    data_q;
  logic             trap_q;
  seq_state_e       state;

  logic start_ld, elem_done, last_done, rep_reload, trap_set, swreq_clr;
  logic cnt_nz, saved_nz, cnt_is_one, half_hit;
  logic ctl_wr;
  logic [AW-1:0] src_addr, dst_addr;
  logic src_rl, dst_rl, cnt_rl;

  assign ctl_wr = cfg_we && (cfg_sel == SEL_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q        <= cfg_wdata[CTL_W-1:0];
      ctl_q[CB_SW] <= cfg_wdata[CB_SW] & cfg_wdata[CB_EN];
    end else if (swreq_clr) begin
      ctl_q[CB_SW] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        trap_q <= 1'b0;
    else if (ctl_wr)   trap_q <= 1'b0;
    else if (trap_set) trap_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else if (state == ST_RD && bus_ready) data_q <= bus_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_done <= 1'b0;
      irq_half <= 1'b0;
    end else begin
      irq_done <= last_done & ctl_q[CB_DONE];
      irq_half <= half_hit & ctl_q[CB_HALF];
    end
  end

  assign src_rl = (start_ld | rep_reload) & ctl_q[CB_RLS];
  assign dst_rl = (start_ld | rep_reload) & ctl_q[CB_RLD];
  assign cnt_rl = rep_reload | (start_ld & (ctl_q[CB_RLC] | ctl_q[CB_XM]));

  dma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctl_q[CB_EN]),
    .trap_en    (ctl_q[CB_TRAP]),
    .trap_q     (trap_q),
    .xmode      (ctl_q[CB_XM+:2]),
    .flow       (ctl_q[CB_FLOW+:2]),
    .rl_cnt     (ctl_q[CB_RLC]),
    .req        (ctl_q[CB_SW] | hw_req),
    .cnt_nz     (cnt_nz),
    .saved_nz   (saved_nz),
    .cnt_is_one (cnt_is_one),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .state      (state),
    .start_ld   (start_ld),
    .elem_done  (elem_done),
    .last_done  (last_done),
    .rep_reload (rep_reload),
    .trap_set   (trap_set),
    .swreq_clr  (swreq_clr)
  );

  dma_addr_unit #(.AW(AW)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we && cfg_sel == SEL_SRC),
    .wr_val (cfg_wdata[AW-1:0]),
    .reload (src_rl),
    .step   (elem_done),
    .mode   (ctl_q[CB_SM+:2]),
    .size   (ctl_q[CB_SIZE+:2]),
    .addr   (src_addr)
  );

  dma_addr_unit #(.AW(AW)) u_dst (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we && cfg_sel == SEL_DST),
    .wr_val (cfg_wdata[AW-1:0]),
    .reload (dst_rl),
    .step   (elem_done),
    .mode   (ctl_q[CB_DM+:2]),
    .size   (ctl_q[CB_SIZE+:2]),
    .addr   (dst_addr)
  );

  dma_cnt_unit #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we && cfg_sel == SEL_CNT),
    .wr_val     (cfg_wdata[CW-1:0]),
    .reload     (cnt_rl),
    .dec        (elem_done),
    .cnt_nz     (cnt_nz),
    .saved_nz   (saved_nz),
    .cnt_is_one (cnt_is_one),
    .half_hit   (half_hit)
  );

  assign bus_req          = (state == ST_RD) || (state == ST_WR) || (state == ST_WB);
  assign bus_we           = (state == ST_WR) || (state == ST_WB);
  assign bus_addr         = (state == ST_WR) ? dst_addr : src_addr;
  assign bus_size         = ctl_q[CB_SIZE+:2];
  assign bus_wdata        = data_q;
  assign trap             = trap_q;
  assign chan_active      = (state != ST_IDLE);
  assign soft_req_pending = ctl_q[CB_SW];
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          trap_en,
  input logic          bus_req,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_err,
  input logic          trap,
  input logic          irq_done
);
  // R14: a stalled beat keeps its request and payload
  a_r14_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready && en) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R13: a disabled channel issues nothing on the following cycle
  a_r13_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bus_req);

  // R11: the trap only rises after an erroring read beat with trapping on
  a_r11_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap) |-> $past(bus_req && bus_ready && bus_err && !bus_we && trap_en));

  // R11: a trapped channel stays off the bus
  a_r11_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !bus_req);

  // R7: a done pulse follows a completed beat
  a_r7_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> $past(bus_req && bus_ready));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (ctl_q[dma_chan_pkg::CB_EN]),
  .trap_en   (ctl_q[dma_chan_pkg::CB_TRAP]),
  .bus_req   (bus_req),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err),
  .trap      (trap),
  .irq_done  (irq_done)
);

// File: tb/dma_chan_engine_bench.sv
`timescale 1ns/1ps
module dma_chan_engine_bench;
  localparam int AW = 24;
  localparam int CW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [31:0]   cfg_wdata = '0;
  logic          hw_req = 1'b0;
  logic          bus_req, bus_we;
  logic          bus_ready = 1'b0;
  logic          bus_err = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          irq_done, irq_half, trap, chan_active, soft_req_pending;

  dma_chan_engine #(.AW(AW), .CW(CW), .DW(DW), .RW(32)) u_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hw_req(hw_req), .bus_req(bus_req), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_done(irq_done), .irq_half(irq_half), .trap(trap),
    .chan_active(chan_active), .soft_req_pending(soft_req_pending)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [AW-1:0] m_src, m_dst, m_src_s, m_dst_s, m_err_addr;
  logic [31:0]   m_cnt, m_cnt_s, m_d;
  logic [1:0]    m_flow, m_size, m_sm, m_dm;
  bit            m_rep, m_rls, m_rld, m_rlc, m_trap_en, m_halt, m_err_arm, stall;
  int            m_phase, rd_n, wr_n, n_done, n_half;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a};
  endfunction

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] mode, input logic [1:0] size);
    logic [AW-1:0] d;
    d = (size == 2'b00) ? AW'(1) : (size == 2'b01) ? AW'(2) : AW'(4);
    if (mode == 2'b01) return a + d;
    if (mode == 2'b10) return a - d;
    return a;
  endfunction

  function automatic logic [31:0] mk(input bit en, input bit half, input bit done, input bit sw,
                                     input logic [1:0] size, input logic [1:0] flow, input logic [1:0] xm,
                                     input logic [1:0] dm, input logic [1:0] sm, input bit trp,
                                     input bit rls, input bit rld, input bit rlc);
    return {14'd0, rlc, rld, rls, trp, sm, dm, xm, flow, size, sw, done, half, en};
  endfunction

  task automatic elem_end();
    m_src   = stepped(m_src, m_sm, m_size);
    m_dst   = stepped(m_dst, m_dm, m_size);
    m_phase = 0;
    m_cnt   = m_cnt - 1;
    if (m_cnt == 0 && m_rep) begin
      m_cnt = m_cnt_s;
      if (m_rls) m_src = m_src_s;
      if (m_rld) m_dst = m_dst_s;
    end
  endtask

  // bus slave with back-pressure; every accepted beat is checked (R2 R3 R4 R5 R14)
  always @(negedge clk) begin
    bus_ready <= 1'b0;
    bus_err   <= 1'b0;
    if (irq_done) n_done++;
    if (irq_half) n_half++;
    if (rst_n && bus_req && !stall && ($urandom % 4 != 0)) begin
      logic          e;
      logic          exp_we;
      logic [AW-1:0] exp_a;
      exp_we = (m_phase != 0);
      exp_a  = (m_phase == 1) ? m_dst : m_src;
      chk(!m_halt && bus_we == exp_we && bus_addr == exp_a && bus_size == m_size,
          "R2 R3 R4 R5 beat dir/addr", {bus_we, bus_addr}, {exp_we, exp_a});
      if (exp_we) chk(bus_wdata == m_d, "R3 R4 write data", bus_wdata, m_d);
      e = m_err_arm && !bus_we && (bus_addr == m_err_addr);
      if (e) m_err_arm = 1'b0;
      bus_ready <= 1'b1;
      bus_rdata <= pat(bus_addr);
      bus_err   <= e;
      if (m_phase == 0) begin
        m_d = pat(m_src);
        rd_n++;
        if (e && m_trap_en) m_halt = 1'b1;
        else if (m_flow == 2'b10) elem_end();
        else m_phase = 1;
      end else if (m_phase == 1) begin
        wr_n++;
        if (m_flow == 2'b01) m_phase = 2;
        else elem_end();
      end else begin
        wr_n++;
        elem_end();
      end
    end
  end

  task automatic model_reset();
    m_phase = 0; m_halt = 0; rd_n = 0; wr_n = 0; m_err_arm = 0;
  endtask

  task automatic model_start();
    if (m_rls) m_src = m_src_s;
    if (m_rld) m_dst = m_dst_s;
    if (m_rlc || m_rep) m_cnt = m_cnt_s;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [31:0] v);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    case (s)
      2'd1: begin m_src = v[AW-1:0]; m_src_s = v[AW-1:0]; end
      2'd2: begin m_dst = v[AW-1:0]; m_dst_s = v[AW-1:0]; end
      2'd3: begin m_cnt = v; m_cnt_s = v; end
      default: begin
        m_size = v[5:4]; m_flow = v[7:6]; m_rep = v[8]; m_dm = v[11:10]; m_sm = v[13:12];
        m_trap_en = v[14]; m_rls = v[15]; m_rld = v[16]; m_rlc = v[17];
      end
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_hw();
    hw_req = 1'b1;
    @(negedge clk);
    hw_req = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int t = 0;
    while (q < 16) begin
      @(negedge clk);
      t++;
      q = bus_req ? 0 : q + 1;
      if (t > 5000) begin
        chk(1'b0, "watchdog wait", t, 5000);
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog global", cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    int d0, h0;
    bit seen;
    void'($urandom(32'h00C0FFEE));
    stall = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({bus_req, bus_we, irq_done, irq_half, trap, chan_active, soft_req_pending} == 7'd0,
        "R1 reset outputs", {bus_req, bus_we, irq_done, irq_half, trap, chan_active, soft_req_pending}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R7 R12: continuous copy, one software request, word size, both addresses up
    model_reset(); d0 = n_done; h0 = n_half;
    cfg(2'd1, 32'h001000); cfg(2'd2, 32'h002000); cfg(2'd3, 32'd6);
    model_start();
    cfg(2'd0, mk(1, 1, 1, 1, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01, 0, 0, 0, 0));
    wait_quiet();
    chk(rd_n == 6 && wr_n == 6, "R6 continuous element count", {rd_n, wr_n}, {32'd6, 32'd6});
    chk(n_done - d0 == 1, "R7 done pulse count", n_done - d0, 1);
    chk(n_half - h0 == 1, "R12 half pulse count", n_half - h0, 1);
    chk(!chan_active && !soft_req_pending, "R7 inactive and request cleared", {chan_active, soft_req_pending}, 0);

    // R4 R6 R2: one-shot null-write flow, halfword, source up, destination down, hardware requests
    model_reset(); d0 = n_done;
    cfg(2'd1, 32'h000400); cfg(2'd2, 32'h000800); cfg(2'd3, 32'd3);
    cfg(2'd0, mk(1, 0, 1, 0, 2'b01, 2'b01, 2'b00, 2'b10, 2'b01, 0, 0, 0, 0));
    model_start();
    pulse_hw(); wait_quiet();
    chk(rd_n == 1 && wr_n == 2, "R4 R6 one element per request", {rd_n, wr_n}, {32'd1, 32'd2});
    chk(chan_active == 1'b1, "R6 waits for next request", chan_active, 1);
    pulse_hw(); wait_quiet();
    pulse_hw(); wait_quiet();
    chk(rd_n == 3 && wr_n == 6, "R4 three elements", {rd_n, wr_n}, {32'd3, 32'd6});
    chk(n_done - d0 == 1 && !chan_active, "R7 one-shot done", {n_done - d0, chan_active}, 2);

    // R5 R2: read-only, byte, source held
    model_reset();
    cfg(2'd1, 32'h00ABCD); cfg(2'd3, 32'd4);
    model_start();
    cfg(2'd0, mk(1, 0, 0, 1, 2'b00, 2'b10, 2'b10, 2'b00, 2'b00, 0, 0, 0, 0));
    wait_quiet();
    chk(rd_n == 4 && wr_n == 0, "R5 reads only", {rd_n, wr_n}, {32'd4, 32'd0});

    // R8: repeated continuous with address reloads
    model_reset(); d0 = n_done;
    cfg(2'd1, 32'h003000); cfg(2'd2, 32'h004000); cfg(2'd3, 32'd3);
    model_start();
    cfg(2'd0, mk(1, 0, 1, 1, 2'b01, 2'b00, 2'b11, 2'b01, 2'b01, 0, 1, 1, 0));
    wait_quiet();
    chk(chan_active && !soft_req_pending, "R8 stays active after zero", {chan_active, soft_req_pending}, 2);
    pulse_hw(); wait_quiet();
    chk(rd_n == 6 && wr_n == 6, "R8 second run with restored count", {rd_n, wr_n}, {32'd6, 32'd6});
    chk(n_done - d0 == 2, "R8 done per run", n_done - d0, 2);
    cfg(2'd0, 32'd0);
    @(negedge clk);
    chk(!chan_active, "R13 disable leaves active state", chan_active, 0);

    // R9 R10: zero count request dropped, count reload on start only
    model_reset(); d0 = n_done;
    cfg(2'd1, 32'h000100); cfg(2'd3, 32'd2);
    model_start();
    cfg(2'd0, mk(1, 0, 1, 1, 2'b00, 2'b10, 2'b10, 2'b00, 2'b01, 0, 0, 0, 0));
    wait_quiet();
    chk(rd_n == 2, "R10 first run", rd_n, 2);
    cfg(2'd0, mk(1, 0, 1, 1, 2'b00, 2'b10, 2'b10, 2'b00, 2'b01, 0, 0, 0, 0));
    wait_quiet();
    chk(rd_n == 2 && !soft_req_pending && !chan_active, "R9 zero count dropped",
        {rd_n, soft_req_pending, chan_active}, {32'd2, 2'b00});
    cfg(2'd0, mk(1, 0, 1, 1, 2'b00, 2'b10, 2'b10, 2'b00, 2'b01, 0, 0, 0, 1));
    model_start();
    wait_quiet();
    chk(rd_n == 4 && n_done - d0 == 2, "R9 R10 count restored, source continues",
        {rd_n, n_done - d0}, {32'd4, 32'd2});

    // R11: trapping read error
    model_reset(); d0 = n_done;
    cfg(2'd1, 32'h005000); cfg(2'd2, 32'h006000); cfg(2'd3, 32'd4);
    m_err_addr = 24'h005004; m_err_arm = 1'b1;
    model_start();
    cfg(2'd0, mk(1, 0, 1, 1, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01, 1, 0, 0, 0));
    wait_quiet();
    chk(trap && !chan_active && rd_n == 2 && wr_n == 1, "R11 trap stops channel",
        {trap, chan_active, rd_n[7:0], wr_n[7:0]}, {2'b10, 8'd2, 8'd1});
    pulse_hw(); wait_quiet();
    chk(rd_n == 2 && n_done == d0, "R11 trapped channel ignores request", rd_n, 2);
    cfg(2'd0, 32'd0);
    chk(!trap, "R11 control write clears trap", trap, 0);

    // R11: error without trapping keeps going
    model_reset(); d0 = n_done;
    cfg(2'd1, 32'h007000); cfg(2'd2, 32'h008000); cfg(2'd3, 32'd3);
    m_err_addr = 24'h007000; m_err_arm = 1'b1;
    model_start();
    cfg(2'd0, mk(1, 0, 1, 1, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01, 0, 0, 0, 0));
    wait_quiet();
    chk(!trap && rd_n == 3 && wr_n == 3 && n_done - d0 == 1, "R11 run continues after error",
        {trap, rd_n[7:0], wr_n[7:0]}, {1'b0, 8'd3, 8'd3});

    // R13 R14: abort during a stalled beat, then requests ignored
    model_reset();
    cfg(2'd1, 32'h009000); cfg(2'd2, 32'h00A000); cfg(2'd3, 32'd20);
    stall = 1'b1;
    model_start();
    cfg(2'd0, mk(1, 0, 0, 1, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    chk(bus_req && !bus_we && bus_addr == 24'h009000, "R14 stalled request held", {bus_req, bus_addr}, {1'b1, 24'h009000});
    cfg(2'd0, 32'd0);
    @(negedge clk);
    chk(!bus_req && !chan_active, "R13 abort next cycle", {bus_req, chan_active}, 0);
    stall = 1'b0;
    seen = 1'b0;
    pulse_hw(); pulse_hw();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_req) seen = 1'b1;
    end
    chk(!seen && rd_n == 0, "R13 disabled channel ignores requests", seen, 0);

    // random continuous runs across flows, sizes and address modes
    for (int it = 0; it < 8; it++) begin
      logic [1:0] fl, sz, smd, dmd;
      int c;
      fl = 2'($urandom % 3); sz = 2'($urandom % 3);
      smd = 2'($urandom % 3); dmd = 2'($urandom % 3);
      c = 1 + int'($urandom % 8);
      model_reset(); d0 = n_done;
      cfg(2'd1, $urandom & 32'h00FF_FFFF);
      cfg(2'd2, $urandom & 32'h00FF_FFFF);
      cfg(2'd3, c);
      model_start();
      cfg(2'd0, mk(1, 0, 1, 1, sz, fl, 2'b10, dmd, smd, 0, 0, 0, 0));
      wait_quiet();
      chk(rd_n == c && wr_n == c * ((fl == 2'b00) ? 1 : (fl == 2'b01) ? 2 : 0),
          "R3 R4 R5 R6 random beats", {rd_n, wr_n}, c);
      chk(n_done - d0 == 1 && !chan_active && !soft_req_pending, "R7 random done",
          {n_done - d0, chan_active, soft_req_pending}, 1);
    end

    finish_run();
  end
endmodule